// File: doc/BRIEF.md
# Segmented Ready/Valid Pipeline

This block carries a payload from a source port to a sink port through a chain of single-slot VALID/READY stages. Data moves forward one stage per clock. Backpressure moves backward. No beat is lost, duplicated or reordered, and the block sustains one beat per cycle when nothing stalls.

Most stages are plain slots. A plain slot registers VALID and data only and passes READY straight back through a gate. At a configurable interval K, a plain slot is replaced by a two-entry skid slot. A skid slot registers the backward READY path as well as the forward path. A READY path can therefore ripple through at most K-1 plain slots before it reaches a register. This lets the designer choose between register area and the depth of the READY logic.

The stage count N, the skid interval K and the payload width are parameters. The reset is synchronous and active low.

Top module: `rv_segmented_pipe`

## Requirements
- R1: After reset, and whenever reset is held low, every slot is empty: `snk_valid` is 0 and `src_ready` is 1.
- R2: Every beat accepted at the source (`src_valid` and `src_ready` both high at a clock edge) is delivered exactly once at the sink, in acceptance order, under any pattern of source VALID and sink READY. The sink delivers no beat that was not accepted.
- R3: While `snk_valid` is 1 and `snk_ready` is 0, both `snk_valid` and `snk_data` hold their values at the next edge.
- R4: With an empty pipeline, `src_valid` held at 1 and `snk_ready` held at 1, `src_ready` stays at 1 every cycle. The first beat appears at the sink N cycles after it is accepted. The sink then delivers one beat on every cycle.
- R5: Stage index i (0 = nearest the source) is a skid slot when (i+1) is a multiple of K, and a plain slot otherwise. Starting empty, with `snk_ready` held at 0 and `src_valid` held at 1, the block accepts exactly N + floor(N/K) beats and then holds `src_ready` at 0.
- R6: `src_data` is ignored in every cycle where `src_valid` is 0: no such value ever reaches the sink.
- R7: Starting from a full pipeline, with `snk_ready` held at 1 and no new input, `snk_valid` stays at 1 for N + floor(N/K) consecutive cycles while the pipeline drains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | 1 | Source offers a beat |
| src_ready | output | 1 | Pipeline can take a beat |
| src_data | input | WIDTH | Source payload |
| snk_valid | output | 1 | Pipeline offers a beat to the sink |
| snk_ready | input | 1 | Sink takes the offered beat |
| snk_data | output | WIDTH | Sink payload |

## Verification
A slot that overwrites a held beat, or a skid slot that drains its spare entry in the wrong order, shows up at the sink as a missing, repeated or swapped value. This appears once the affected beat has travelled the remaining stages, which is at most N cycles plus the stall time. A wrong skid placement or a miscounted spare entry changes how many beats are accepted before `src_ready` falls, and the capacity sweep reports this at once. A bubble inserted on refill breaks the unbroken VALID run expected during a drain or at full rate, in the first cycle where it happens.

// File: rtl/rv_pipe_pkg.sv
package rv_pipe_pkg;

   typedef enum logic {SLOT_PLAIN = 1'b0, SLOT_SKID = 1'b1} slot_kind_e;

   // Kind of the slot at a given index for a given skid interval.
   function automatic slot_kind_e slot_kind(input int idx, input int interval);
      return (((idx + 1) % interval) == 0) ? SLOT_SKID : SLOT_PLAIN;
   endfunction

   // Number of beats the chain holds when fully stalled.
   function automatic int chain_capacity(input int stages, input int interval);
      return stages + (stages / interval);
   endfunction

endpackage

// File: rtl/rv_plain_slot.sv
module rv_plain_slot #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [WIDTH-1:0] dn_data
);

   logic             full_q;
   logic [WIDTH-1:0] data_q;

   // Open when empty or when the held beat is leaving this cycle.
   assign up_ready = !full_q || dn_ready;
   assign dn_valid = full_q;
   assign dn_data  = data_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        full_q <= 1'b0;
      else if (up_ready) full_q <= up_valid;
   end

   always_ff @(posedge clk) begin
      if (up_ready && up_valid) data_q <= up_data;
   end

   assert_plain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && !dn_ready) |=> (full_q && $stable(data_q)));

   assert_plain_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && up_ready) |=> (full_q && data_q == $past(up_data)));

endmodule

// File: rtl/rv_skid_slot.sv
module rv_skid_slot #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up_valid,
   output logic             up_ready,
   input  logic [WIDTH-1:0] up_data,
   output logic             dn_valid,
   input  logic             dn_ready,
   output logic [WIDTH-1:0] dn_data
);

   logic             main_v, spare_v;
   logic [WIDTH-1:0] main_d, spare_d;
   logic             take, accept;

   // READY comes straight from a flop: no path from dn_ready.
   assign up_ready = !spare_v;
   assign dn_valid = main_v;
   assign dn_data  = main_d;
   assign take     = main_v && dn_ready;
   assign accept   = up_valid && !spare_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         main_v  <= 1'b0;
         spare_v <= 1'b0;
      end else if (spare_v) begin
         if (take) spare_v <= 1'b0;
      end else if (accept) begin
         if (main_v && !take) spare_v <= 1'b1;
         else                 main_v  <= 1'b1;
      end else if (take) begin
         main_v <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (spare_v) begin
         if (take) main_d <= spare_d;
      end else if (accept) begin
         if (main_v && !take) spare_d <= up_data;
         else                 main_d  <= up_data;
      end
   end

   assert_skid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (main_v && !dn_ready) |=> (main_v && $stable(main_d)));

   assert_spare_behind_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
      spare_v |-> main_v);

   assert_spare_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (spare_v && !dn_ready) |=> (spare_v && $stable(spare_d)));

   assert_spare_drains_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (spare_v && dn_ready) |=> (main_v && main_d == $past(spare_d)));

endmodule

// File: rtl/rv_segmented_pipe.sv
module rv_segmented_pipe
   import rv_pipe_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int STAGES = 5,
   parameter int SKID_K = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_valid,
   output logic             src_ready,
   input  logic [WIDTH-1:0] src_data,
   output logic             snk_valid,
   input  logic             snk_ready,
   output logic [WIDTH-1:0] snk_data
);

   localparam int CAPACITY = chain_capacity(STAGES, SKID_K);
   localparam int OCC_W    = $clog2(CAPACITY + 1) + 1;

   if (WIDTH < 1)  begin : g_bad_width  $error("WIDTH must be at least 1");  end
   if (STAGES < 1) begin : g_bad_stages $error("STAGES must be at least 1"); end
   if (SKID_K < 1) begin : g_bad_k      $error("SKID_K must be at least 1"); end

   logic [STAGES:0]            lnk_v;
   logic [STAGES:0]            lnk_r;
   logic [STAGES:0][WIDTH-1:0] lnk_d;

   assign lnk_v[0]      = src_valid;
   assign lnk_d[0]      = src_data;
   assign src_ready     = lnk_r[0];
   assign snk_valid     = lnk_v[STAGES];
   assign snk_data      = lnk_d[STAGES];
   assign lnk_r[STAGES] = snk_ready;

   for (genvar i = 0; i < STAGES; i++) begin : g_slot
      if (slot_kind(i, SKID_K) == SLOT_SKID) begin : g_skid
         rv_skid_slot #(.WIDTH(WIDTH)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (lnk_v[i]),
            .up_ready (lnk_r[i]),
            .up_data  (lnk_d[i]),
            .dn_valid (lnk_v[i+1]),
            .dn_ready (lnk_r[i+1]),
            .dn_data  (lnk_d[i+1])
         );
      end else begin : g_plain
         rv_plain_slot #(.WIDTH(WIDTH)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (lnk_v[i]),
            .up_ready (lnk_r[i]),
            .up_data  (lnk_d[i]),
            .dn_valid (lnk_v[i+1]),
            .dn_ready (lnk_r[i+1]),
            .dn_data  (lnk_d[i+1])
         );
      end
   end

   // Occupancy tracked at the ports only, for the bound check below.
   logic [OCC_W-1:0] occ_q;
   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else        occ_q <= occ_q + OCC_W'(src_valid && src_ready)
                                 - OCC_W'(snk_valid && snk_ready);
   end

   assert_occupancy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(CAPACITY));

   assert_empty_has_no_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (occ_q == '0) |-> !snk_valid);

   assert_sink_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

endmodule

// File: tb/test_rv_segmented_pipe.sv
module test_rv_segmented_pipe;

   localparam int W   = 8;
   localparam int N   = 5;
   localparam int K   = 2;
   localparam int CAP = N + N / K;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         src_valid = 1'b0;
   logic         snk_ready = 1'b0;
   logic [W-1:0] src_data = '0;
   logic         src_ready, snk_valid;
   logic [W-1:0] snk_data;

   always #5 clk = ~clk;

   rv_segmented_pipe #(.WIDTH(W), .STAGES(N), .SKID_K(K)) i_rv_segmented_pipe (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
      .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data)
   );

   int tests = 0, fails = 0;
   bit done = 1'b0;

   logic [W-1:0] exp_q [0:8191];
   int wr_i = 0, rd_i = 0;
   int cyc_no = 0;
   bit src_fire, snk_fire;
   bit prev_stall = 1'b0;
   logic [W-1:0] prev_data = '0;
   logic [W-1:0] seq = '0;

   task automatic check(input bit ok, input string req, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc_no);
      end
   endtask

   // One cycle: drive after the falling edge, observe before the rising edge.
   task automatic step(input bit sv, input logic [W-1:0] sd, input bit sr);
      @(negedge clk);
      src_valid = sv;
      src_data  = sd;
      snk_ready = sr;
      #1;
      cyc_no++;
      src_fire = src_valid && src_ready;
      snk_fire = snk_valid && snk_ready;
      if (prev_stall) begin
         check(snk_valid == 1'b1, "R3 valid held", int'(snk_valid), 1);
         check(snk_data == prev_data, "R3 data held", int'(snk_data), int'(prev_data));
      end
      prev_stall = snk_valid && !snk_ready;
      prev_data  = snk_data;
      if (src_fire) begin
         exp_q[wr_i % 8192] = sd;
         wr_i++;
      end
      if (snk_fire) begin
         if (rd_i >= wr_i) check(1'b0, "R2 extra beat", int'(snk_data), -1);
         else begin
            check(snk_data == exp_q[rd_i % 8192], "R2/R6 order", int'(snk_data),
                  int'(exp_q[rd_i % 8192]));
            rd_i++;
         end
      end
   endtask

   // Valid beats carry a running sequence; idle cycles carry noise.
   function automatic logic [W-1:0] pick(input bit v);
      return v ? seq : W'($urandom);
   endfunction

   task automatic drain(input int n);
      for (int c = 0; c < n; c++) step(1'b0, W'($urandom), 1'b1);
   endtask

   task automatic storm(input int n, input int pv, input int pr);
      for (int c = 0; c < n; c++) begin
         bit v, r;
         v = ($urandom % 100) < pv;
         r = ($urandom % 100) < pr;
         step(v, pick(v), r);
         if (src_fire) seq++;
      end
   endtask

   initial begin
      int first_acc, first_out, accepted, run;
      // R1: state while reset is held and just after release
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(snk_valid == 1'b0, "R1 snk_valid in reset", int'(snk_valid), 0);
      check(src_ready == 1'b1, "R1 src_ready in reset", int'(src_ready), 1);
      rst_n = 1'b1;
      step(1'b0, '0, 1'b0);
      check(snk_valid == 1'b0, "R1 snk_valid after reset", int'(snk_valid), 0);
      check(src_ready == 1'b1, "R1 src_ready after reset", int'(src_ready), 1);

      // R2 R3 R6: stall storms at several densities
      storm(1500, 70, 60);
      storm(1500, 95, 25);
      storm(1500, 30, 90);
      drain(3 * CAP);
      check(rd_i == wr_i, "R2 conservation after storms", rd_i, wr_i);

      // R4: full rate with latency N
      first_acc = -1; first_out = -1; run = 0;
      for (int c = 0; c < 60; c++) begin
         step(1'b1, seq, 1'b1);
         if (src_fire) seq++;
         check(src_ready == 1'b1, "R4 src_ready high", int'(src_ready), 1);
         if (src_fire && first_acc < 0) first_acc = cyc_no;
         if (snk_fire && first_out < 0) first_out = cyc_no;
         if (first_out >= 0 && c < 59) run += int'(snk_valid);
      end
      check(first_out - first_acc == N, "R4 latency", first_out - first_acc, N);
      check(run == 59 - (first_out - first_acc), "R4 one beat per cycle",
            run, 59 - (first_out - first_acc));
      drain(3 * CAP);
      check(rd_i == wr_i, "R2 conservation after full rate", rd_i, wr_i);

      // R5: capacity with the sink stalled
      accepted = 0;
      for (int c = 0; c < 4 * CAP; c++) begin
         step(1'b1, seq, 1'b0);
         if (src_fire) begin seq++; accepted++; end
      end
      check(accepted == CAP, "R5 stalled capacity", accepted, CAP);
      check(src_ready == 1'b0, "R5 src_ready low when full", int'(src_ready), 0);

      // R7: drain from full with no bubble
      run = 0;
      for (int c = 0; c < CAP; c++) begin
         step(1'b0, W'($urandom), 1'b1);
         run += int'(snk_fire);
      end
      check(run == CAP, "R7 unbroken drain", run, CAP);
      step(1'b0, '0, 1'b1);
      check(snk_valid == 1'b0, "R7 empty after drain", int'(snk_valid), 0);
      check(rd_i == wr_i, "R2 conservation after drain", rd_i, wr_i);

      // R1: reset in the middle of traffic
      for (int c = 0; c < CAP; c++) begin
         step(1'b1, seq, 1'b0);
         if (src_fire) seq++;
      end
      @(negedge clk);
      rst_n = 1'b0;
      src_valid = 1'b0;
      @(negedge clk);
      check(snk_valid == 1'b0, "R1 snk_valid after mid reset", int'(snk_valid), 0);
      check(src_ready == 1'b1, "R1 src_ready after mid reset", int'(src_ready), 1);
      rst_n = 1'b1;
      rd_i = wr_i;
      prev_stall = 1'b0;
      storm(800, 60, 50);
      drain(3 * CAP);
      check(rd_i == wr_i, "R2 conservation after mid reset", rd_i, wr_i);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_no, 0);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule